// File: doc/BRIEF.md
# Channel-Restricted LUT Routing Tile

This block is one tile of a small reconfigurable fabric that accelerates simple software inner loops. The tile holds two switch matrices joined east-to-west by a horizontal track, a 3-input, 2-output lookup table that reads from that track, and a bottom crossbar. Each switch matrix has four channels on each side. A signal may cross a switch matrix only on the channel index it already uses. The bottom crossbar is the only place where a signal can move to another index. The lookup table is an 8-word by 2-bit memory. Each of its inputs comes from a channel on the left or right side of the table. Its outputs can drive only bottom channels.

All routing and table contents sit in a single 96-bit configuration chain. The chain is loaded serially with `cfg_en` high. The datapath is purely combinational. Its outputs count as meaningful only once `cfg_en` is low. While loading is in progress every routing output and the error flag are held at 0.

Top module: `route_tile`

## Requirements
- R1: A synchronous active-high reset clears all 96 configuration bits. After reset every routing output, `cfg_err` and `cfg_dout` read 0, whatever the input values.
- R2: On each clock with `cfg_en` high, `cfg_din` enters bit 0 of the chain and every bit moves up one place. `cfg_dout` shows bit 95, so a 96-bit word is sent most significant bit first. With `cfg_en` low the chain holds its contents.
- R3: While `cfg_en` is high, every routing output and `cfg_err` read 0.
- R4: Each switch matrix has one enable bit per side pairing per channel. The pairings are numbered NS=0, EW=1, NE=2, NW=3, SE=4, SW=5. The enable bit joins channel c of both sides in both directions. The left matrix uses bits 72+4p+c and the right matrix uses bits 48+4p+c.
- R5: A switch-matrix output channel with no enabled pairing reads 0. No signal leaves a switch matrix on a channel index other than the one it entered on.
- R6: The east side of the left matrix and the west side of the right matrix are joined channel for channel.
- R7: Table word a sits at bits 32+2a+k, where k is the output number. The table address is {in2,in1,in0}.
- R8: Table input i has a 4-bit select at bits 20+4i. Bit 3 forces the input to 0. Bit 2 picks the side: 0 takes the left matrix's east output and 1 takes the right matrix's west output. Bits 1:0 pick the channel.
- R9: Table output k has a 4-bit mask at bits 12+4k. The output drives each bottom channel whose mask bit is set, and those drives are ORed with `bot_in` to form the bottom bus.
- R10: Bottom output channel c has a 3-bit field at bits 3c. Bit 2 enables the channel, and bits 1:0 give the bottom bus channel it copies. A disabled channel reads 0.
- R11: `cfg_err` is 1, with `cfg_en` low, exactly when some bottom channel is set in both output masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_din | input | 1 | Serial configuration data in |
| cfg_dout | output | 1 | Chain bit 95 |
| l_n_in | input | 4 | Left matrix north channels in |
| l_s_in | input | 4 | Left matrix south channels in |
| l_w_in | input | 4 | Left matrix west channels in |
| l_n_out | output | 4 | Left matrix north channels out |
| l_s_out | output | 4 | Left matrix south channels out |
| l_w_out | output | 4 | Left matrix west channels out |
| r_n_in | input | 4 | Right matrix north channels in |
| r_s_in | input | 4 | Right matrix south channels in |
| r_e_in | input | 4 | Right matrix east channels in |
| r_n_out | output | 4 | Right matrix north channels out |
| r_s_out | output | 4 | Right matrix south channels out |
| r_e_out | output | 4 | Right matrix east channels out |
| bot_in | input | 4 | Bottom channels from outside |
| bot_out | output | 4 | Bottom crossbar outputs |
| cfg_err | output | 1 | Two table outputs share a bottom channel |

## Verification
The bound checker watches these on every cycle: reset clearing the chain, shift-in and hold of the chain, silence of all outputs during loading, zero on disabled bottom channels, a silent left matrix when its pairings are all off, and no error flag while the masks are disjoint. Other behaviour needs configured stimulus from the bench scenarios. That covers index-preserving passage in both directions, the link between the two matrices, the full table truth over all eight addresses, the side, channel and force-zero input selects, index changes in the crossbar, and the serial order of the chain read back through `cfg_dout`.

// File: rtl/tile_pkg.sv
package tile_pkg;

    localparam int CH        = 4;
    localparam int CH_W      = $clog2(CH);
    localparam int LUT_IN    = 3;
    localparam int LUT_OUT   = 2;
    localparam int LUT_DEPTH = 1 << LUT_IN;
    localparam int N_PAIR    = 6;

    typedef enum logic [2:0] {
        PR_NS = 3'd0,
        PR_EW = 3'd1,
        PR_NE = 3'd2,
        PR_NW = 3'd3,
        PR_SE = 3'd4,
        PR_SW = 3'd5
    } pair_e;

    typedef logic [CH-1:0] chan_t;

    typedef struct packed {
        chan_t [N_PAIR-1:0] pair;
    } sm_cfg_t;

    typedef struct packed {
        logic            force_zero;
        logic            from_right;
        logic [CH_W-1:0] chan;
    } in_sel_t;

    typedef struct packed {
        logic            enable;
        logic [CH_W-1:0] src;
    } bot_sel_t;

    typedef struct packed {
        sm_cfg_t                              sm_l;
        sm_cfg_t                              sm_r;
        logic [LUT_DEPTH-1:0][LUT_OUT-1:0]    table_bits;
        in_sel_t [LUT_IN-1:0]                 in_sel;
        chan_t [LUT_OUT-1:0]                  out_mask;
        bot_sel_t [CH-1:0]                    bot;
    } tile_cfg_t;

    localparam int CFG_W = $bits(tile_cfg_t);

    // Pass a channel vector through a pairing enable vector.
    function automatic chan_t gate_ch(chan_t sig, chan_t en);
        return sig & en;
    endfunction

endpackage

// File: rtl/cfg_chain.sv
module cfg_chain #(
    parameter int W = 96
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] q,
    output logic         dout
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (shift_en) begin
            q <= {q[W-2:0], din};
        end
    end

    assign dout = q[W-1];

endmodule

// File: rtl/sw_matrix.sv
module sw_matrix
    import tile_pkg::*;
(
    input  sm_cfg_t cfg,
    input  chan_t   n_in,
    input  chan_t   e_in,
    input  chan_t   s_in,
    input  chan_t   w_in,
    output chan_t   n_out,
    output chan_t   e_out,
    output chan_t   s_out,
    output chan_t   w_out
);

    chan_t p_ns, p_ew, p_ne, p_nw, p_se, p_sw;

    assign p_ns = cfg.pair[PR_NS];
    assign p_ew = cfg.pair[PR_EW];
    assign p_ne = cfg.pair[PR_NE];
    assign p_nw = cfg.pair[PR_NW];
    assign p_se = cfg.pair[PR_SE];
    assign p_sw = cfg.pair[PR_SW];

    // Each side sees the other three sides, only on its own channel index.
    assign n_out = gate_ch(s_in, p_ns) | gate_ch(e_in, p_ne) | gate_ch(w_in, p_nw);
    assign s_out = gate_ch(n_in, p_ns) | gate_ch(e_in, p_se) | gate_ch(w_in, p_sw);
    assign e_out = gate_ch(w_in, p_ew) | gate_ch(n_in, p_ne) | gate_ch(s_in, p_se);
    assign w_out = gate_ch(e_in, p_ew) | gate_ch(n_in, p_nw) | gate_ch(s_in, p_sw);

endmodule

// File: rtl/lut_cell.sv
module lut_cell
    import tile_pkg::*;
(
    input  chan_t                             left_ch,
    input  chan_t                             right_ch,
    input  logic [LUT_DEPTH-1:0][LUT_OUT-1:0] table_bits,
    input  in_sel_t [LUT_IN-1:0]              in_sel,
    input  chan_t [LUT_OUT-1:0]               out_mask,
    output chan_t                             drive,
    output logic                              conflict
);

    logic [LUT_IN-1:0]  addr;
    logic [LUT_OUT-1:0] word;

    for (genvar i = 0; i < LUT_IN; i++) begin : g_in
        always_comb begin
            if (in_sel[i].force_zero) begin
                addr[i] = 1'b0;
            end else if (in_sel[i].from_right) begin
                addr[i] = right_ch[in_sel[i].chan];
            end else begin
                addr[i] = left_ch[in_sel[i].chan];
            end
        end
    end

    assign word = table_bits[addr];

    always_comb begin
        drive = '0;
        for (int k = 0; k < LUT_OUT; k++) begin
            drive = drive | (out_mask[k] & {CH{word[k]}});
        end
    end

    chan_t seen, clash;
    always_comb begin
        seen  = '0;
        clash = '0;
        for (int k = 0; k < LUT_OUT; k++) begin
            clash = clash | (seen & out_mask[k]);
            seen  = seen | out_mask[k];
        end
    end

    assign conflict = |clash;

endmodule

// File: rtl/bottom_xbar.sv
module bottom_xbar
    import tile_pkg::*;
(
    input  chan_t             lut_drive,
    input  chan_t             ext_in,
    input  bot_sel_t [CH-1:0] sel,
    output chan_t             out
);

    chan_t bus;
    assign bus = lut_drive | ext_in;

    for (genvar c = 0; c < CH; c++) begin : g_out
        assign out[c] = sel[c].enable & bus[sel[c].src];
    end

endmodule

// File: rtl/route_tile.sv
module route_tile
    import tile_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_en,
    input  logic          cfg_din,
    output logic          cfg_dout,
    input  logic [CH-1:0] l_n_in,
    input  logic [CH-1:0] l_s_in,
    input  logic [CH-1:0] l_w_in,
    output logic [CH-1:0] l_n_out,
    output logic [CH-1:0] l_s_out,
    output logic [CH-1:0] l_w_out,
    input  logic [CH-1:0] r_n_in,
    input  logic [CH-1:0] r_s_in,
    input  logic [CH-1:0] r_e_in,
    output logic [CH-1:0] r_n_out,
    output logic [CH-1:0] r_s_out,
    output logic [CH-1:0] r_e_out,
    input  logic [CH-1:0] bot_in,
    output logic [CH-1:0] bot_out,
    output logic          cfg_err
);

    logic [CFG_W-1:0] cfg_q;
    tile_cfg_t        cfg;

    cfg_chain #(.W(CFG_W)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .shift_en (cfg_en),
        .din      (cfg_din),
        .q        (cfg_q),
        .dout     (cfg_dout)
    );

    assign cfg = tile_cfg_t'(cfg_q);

    chan_t lm_n, lm_s, lm_w, lm_e;
    chan_t rm_n, rm_s, rm_e, rm_w;

    sw_matrix u_sm_l (
        .cfg   (cfg.sm_l),
        .n_in  (l_n_in),
        .e_in  (rm_w),
        .s_in  (l_s_in),
        .w_in  (l_w_in),
        .n_out (lm_n),
        .e_out (lm_e),
        .s_out (lm_s),
        .w_out (lm_w)
    );

    sw_matrix u_sm_r (
        .cfg   (cfg.sm_r),
        .n_in  (r_n_in),
        .e_in  (r_e_in),
        .s_in  (r_s_in),
        .w_in  (lm_e),
        .n_out (rm_n),
        .e_out (rm_e),
        .s_out (rm_s),
        .w_out (rm_w)
    );

    chan_t lut_drive;
    logic  mask_clash;

    lut_cell u_lut (
        .left_ch    (lm_e),
        .right_ch   (rm_w),
        .table_bits (cfg.table_bits),
        .in_sel     (cfg.in_sel),
        .out_mask   (cfg.out_mask),
        .drive      (lut_drive),
        .conflict   (mask_clash)
    );

    chan_t xbar_out;

    bottom_xbar u_xbar (
        .lut_drive (lut_drive),
        .ext_in    (bot_in),
        .sel       (cfg.bot),
        .out       (xbar_out)
    );

    // Outputs are meaningful only once loading has finished.
    assign l_n_out = cfg_en ? '0 : lm_n;
    assign l_s_out = cfg_en ? '0 : lm_s;
    assign l_w_out = cfg_en ? '0 : lm_w;
    assign r_n_out = cfg_en ? '0 : rm_n;
    assign r_s_out = cfg_en ? '0 : rm_s;
    assign r_e_out = cfg_en ? '0 : rm_e;
    assign bot_out = cfg_en ? '0 : xbar_out;
    assign cfg_err = cfg_en ? 1'b0 : mask_clash;

endmodule

// File: rtl/route_tile_chk.sv
module route_tile_chk
    import tile_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cfg_en,
    input logic             cfg_din,
    input logic [CFG_W-1:0] cfg_q,
    input logic [CH-1:0]    l_n_out,
    input logic [CH-1:0]    l_s_out,
    input logic [CH-1:0]    l_w_out,
    input logic [CH-1:0]    r_n_out,
    input logic [CH-1:0]    r_s_out,
    input logic [CH-1:0]    r_e_out,
    input logic [CH-1:0]    bot_out,
    input logic             cfg_err
);

    tile_cfg_t c;
    chan_t     bot_en;

    assign c = tile_cfg_t'(cfg_q);

    always_comb begin
        for (int i = 0; i < CH; i++) begin
            bot_en[i] = c.bot[i].enable;
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> cfg_q == '0); // R1

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> $stable(cfg_q)); // R2

    AST_SHIFT_IN: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> cfg_q[0] == $past(cfg_din)); // R2

    AST_QUIET_LOAD: assert property (@(posedge clk) disable iff (rst)
        cfg_en |-> ((l_n_out | l_s_out | l_w_out | r_n_out | r_s_out | r_e_out | bot_out) == '0
                    && !cfg_err)); // R3

    AST_BOT_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (bot_out & ~bot_en) == '0); // R10

    AST_LEFT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (c.sm_l == '0) |-> (l_n_out | l_s_out | l_w_out) == '0); // R5

    AST_NO_FALSE_ERR: assert property (@(posedge clk) disable iff (rst)
        ((c.out_mask[0] & c.out_mask[1]) == '0) |-> !cfg_err); // R11

endmodule

bind route_tile route_tile_chk u_chk (.*);

// File: tb/tb_route_tile.sv
module tb_route_tile;

    localparam int W = 96;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_en = 1'b0;
    logic       cfg_din = 1'b0;
    logic       cfg_dout;
    logic [3:0] l_n_in = '0, l_s_in = '0, l_w_in = '0;
    logic [3:0] l_n_out, l_s_out, l_w_out;
    logic [3:0] r_n_in = '0, r_s_in = '0, r_e_in = '0;
    logic [3:0] r_n_out, r_s_out, r_e_out;
    logic [3:0] bot_in = '0;
    logic [3:0] bot_out;
    logic       cfg_err;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    route_tile dut (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din), .cfg_dout(cfg_dout),
        .l_n_in(l_n_in), .l_s_in(l_s_in), .l_w_in(l_w_in),
        .l_n_out(l_n_out), .l_s_out(l_s_out), .l_w_out(l_w_out),
        .r_n_in(r_n_in), .r_s_in(r_s_in), .r_e_in(r_e_in),
        .r_n_out(r_n_out), .r_s_out(r_s_out), .r_e_out(r_e_out),
        .bot_in(bot_in), .bot_out(bot_out), .cfg_err(cfg_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Field placement as given in the requirements.
    function automatic logic [W-1:0] set_pair(logic [W-1:0] v, bit right, int p, int c);
        v[(right ? 48 : 72) + 4*p + c] = 1'b1;
        return v;
    endfunction
    function automatic logic [W-1:0] set_tbl(logic [W-1:0] v, int a, int k, bit val);
        v[32 + 2*a + k] = val;
        return v;
    endfunction
    function automatic logic [W-1:0] set_sel(logic [W-1:0] v, int i, bit fz, bit side, int ch);
        v[20 + 4*i +: 4] = {fz, side, 2'(ch)};
        return v;
    endfunction
    function automatic logic [W-1:0] set_mask(logic [W-1:0] v, int k, logic [3:0] m);
        v[12 + 4*k +: 4] = m;
        return v;
    endfunction
    function automatic logic [W-1:0] set_bot(logic [W-1:0] v, int c, bit en, int src);
        v[3*c +: 3] = {en, 2'(src)};
        return v;
    endfunction

    task automatic load(input logic [W-1:0] v, input bit gate_check);
        for (int i = W - 1; i >= 0; i--) begin
            @(negedge clk);
            cfg_en  = 1'b1;
            cfg_din = v[i];
            if (gate_check && i == 50) begin
                #1;
                chk("R3 outputs quiet while loading",
                    {l_n_out, l_s_out, l_w_out, r_n_out, r_s_out, r_e_out, bot_out}, 0);
                chk("R3 cfg_err quiet while loading", cfg_err, 0);
            end
        end
        @(negedge clk);
        cfg_en  = 1'b0;
        cfg_din = 1'b0;
    endtask

    task automatic clear_inputs();
        l_n_in = '0; l_s_in = '0; l_w_in = '0;
        r_n_in = '0; r_s_in = '0; r_e_in = '0;
        bot_in = '0;
    endtask

    task automatic t_reset();
        l_n_in = '1; l_s_in = '1; l_w_in = '1;
        r_n_in = '1; r_s_in = '1; r_e_in = '1; bot_in = '1;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        chk("R1 routing outputs after reset",
            {l_n_out, l_s_out, l_w_out, r_n_out, r_s_out, r_e_out, bot_out}, 0);
        chk("R1 cfg_err after reset", cfg_err, 0);
        chk("R1 cfg_dout after reset", cfg_dout, 0);
        clear_inputs();
    endtask

    task automatic t_switch();
        logic [W-1:0] v = '0;
        v = set_pair(v, 0, 0, 1);   // left NS ch1
        v = set_pair(v, 0, 1, 2);   // left EW ch2
        v = set_pair(v, 0, 2, 3);   // left NE ch3
        v = set_pair(v, 1, 1, 2);   // right EW ch2
        load(v, 0);
        clear_inputs();
        l_n_in = 4'b1111; #1;
        chk("R4 R5 north to south on ch1 only", l_s_out, 4'b0010);
        chk("R5 no north-west pairing", l_w_out, 4'b0000);
        chk("R6 ch3 stops at right matrix", r_e_out, 4'b0000);
        @(negedge clk); clear_inputs(); l_s_in = 4'b1111; #1;
        chk("R4 south to north reverse direction", l_n_out, 4'b0010);
        @(negedge clk); clear_inputs(); l_w_in = 4'b1111; #1;
        chk("R6 west through both matrices on ch2", r_e_out, 4'b0100);
        chk("R5 west does not reach north", l_n_out, 4'b0000);
        @(negedge clk); clear_inputs(); r_e_in = 4'b1111; #1;
        chk("R6 east back to left west on ch2", l_w_out, 4'b0100);
        chk("R5 ch2 not moved to ch3 at left NE", l_n_out, 4'b0000);
        @(negedge clk); clear_inputs(); r_e_in = 4'b1000; #1;
        chk("R5 unrouted ch3 stays dark", l_w_out | l_n_out | l_s_out, 4'b0000);
        clear_inputs();
    endtask

    function automatic logic [W-1:0] lut_cfg(bit zero_in2);
        logic [W-1:0] v = '0;
        v = set_pair(v, 0, 1, 0);
        v = set_pair(v, 0, 1, 1);
        v = set_pair(v, 1, 1, 3);
        for (int a = 0; a < 8; a++) begin
            v = set_tbl(v, a, 0, ^3'(a));
            v = set_tbl(v, a, 1, ($countones(3'(a)) >= 2));
        end
        v = set_sel(v, 0, 0, 0, 0);
        v = set_sel(v, 1, 0, 0, 1);
        v = set_sel(v, 2, zero_in2, 1, 3);
        v = set_mask(v, 0, 4'b0001);
        v = set_mask(v, 1, 4'b0100);
        for (int c = 0; c < 4; c++) v = set_bot(v, c, 1, c);
        return v;
    endfunction

    task automatic t_lut();
        load(lut_cfg(0), 0);
        for (int a = 0; a < 8; a++) begin
            logic [2:0] ad = 3'(a);
            logic par, maj;
            @(negedge clk);
            clear_inputs();
            l_w_in = {2'b00, ad[1], ad[0]};
            r_e_in = {ad[2], 3'b000};
            par = ^ad;
            maj = (ad[0] & ad[1]) | (ad[0] & ad[2]) | (ad[1] & ad[2]);
            #1;
            chk("R7 R8 R9 table truth on bottom", bot_out, {1'b0, maj, 1'b0, par});
            chk("R11 disjoint masks no error", cfg_err, 0);
        end
        load(lut_cfg(1), 0);
        for (int a = 0; a < 4; a++) begin
            logic [2:0] ad = 3'(a);
            @(negedge clk);
            l_w_in = {2'b00, ad[1], ad[0]};
            r_e_in = 4'b1000;
            #1;
            chk("R8 forced-zero input ignores right ch3", bot_out,
                {1'b0, ad[0] & ad[1], 1'b0, ad[0] ^ ad[1]});
        end
        clear_inputs();
    endtask

    task automatic t_bottom();
        logic [W-1:0] v = '0;
        for (int a = 0; a < 8; a++) v = set_tbl(v, a, 1, 1);
        v = set_mask(v, 1, 4'b0010);
        v = set_bot(v, 0, 1, 2);
        v = set_bot(v, 1, 1, 2);
        v = set_bot(v, 2, 1, 1);
        v = set_bot(v, 3, 0, 0);
        load(v, 0);
        clear_inputs(); #1;
        chk("R9 R10 table drive moved ch1 to ch2", bot_out, 4'b0100);
        @(negedge clk); bot_in = 4'b0100; #1;
        chk("R10 ch2 fanned to ch0 and ch1", bot_out, 4'b0111);
        @(negedge clk); bot_in = 4'b0001; #1;
        chk("R10 unselected ch0 input dropped", bot_out, 4'b0100);
        @(negedge clk); bot_in = 4'b1111; #1;
        chk("R10 disabled ch3 stays 0", bot_out[3], 0);
        clear_inputs();
    endtask

    task automatic t_error_and_gate();
        logic [W-1:0] v = '0;
        logic [W-1:0] v2;
        for (int a = 0; a < 8; a++) v = set_tbl(v, a, 0, 1);
        v = set_mask(v, 0, 4'b0110);
        v = set_mask(v, 1, 4'b0011);
        for (int c = 0; c < 4; c++) v = set_bot(v, c, 1, c);
        load(v, 0);
        #1;
        chk("R11 overlap on ch1 flagged", cfg_err, 1);
        chk("R9 shared channel driven", bot_out, 4'b0110);
        v2 = set_mask(v, 1, 4'b1000);
        load(v2, 1);
        #1;
        chk("R11 no overlap no flag", cfg_err, 0);
    endtask

    task automatic t_chain();
        logic [W-1:0] p = '0;
        for (int i = 0; i < W; i++) p[i] = ((i * 7 + 3) % 5) < 2;
        load(p, 0);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            cfg_din = k[0];
        end
        cfg_din = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            @(negedge clk); #1;
            chk("R2 serial readback MSB first after hold", cfg_dout, p[i]);
            cfg_en = 1'b1;
        end
        @(negedge clk);
        cfg_en = 1'b0;
    endtask

    initial begin
        t_reset();
        t_switch();
        t_lut();
        t_bottom();
        t_error_and_gate();
        t_chain();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule